// File: doc/BRIEF.md
# Tap-Code Gain-Search Loop Controller

This block is the synchronous control loop of an all-digital clock generator. It runs on the reference clock and splits it into two-cycle evaluation windows. In the first cycle of each window it raises a clear pulse that resets the external sampling flip-flops. In the second cycle it reads a snapshot of those flip-flops. Each snapshot bit samples a progressively delayed copy of the oscillator clock, and a 1 means that copy had already toggled when the reference edge arrived.

From the snapshot the block decides whether the oscillator is running fast or slow. It computes a fast-side and a slow-side step size and selects one of them with the fast flag. It then moves an 8-bit oscillator control word by that step: down when fast, up when slow, and clamped at both ends. Frequency and phase are corrected together in one mode, with no search that halves its step on each direction change. A lock flag reports that the sampling point sits between the central tap and its slightly later copy.

The snapshot has `2*SIDE+2` bits:
- bits `[SIDE-1:0]` are the early taps;
- bit `SIDE` is the central tap;
- bit `SIDE+1` is the central tap's late copy;
- bits `[2*SIDE+1:SIDE+2]` are the late taps.

Top module: `adpll_gain_loop`

## Requirements
- R1: While `rst_n` is low and after its release, `ctl_word` is 128, and `lock`, `fast` and `gain` are 0.
- R2: `win_clr` is high in the first cycle after reset release and alternates every cycle after that. `ctl_word`, `fast`, `gain` and `lock` change only on the clock edge that ends a cycle in which `win_clr` is low (an evaluation edge).
- R3: When the central tap `taps[SIDE]` is 1, the evaluation sets `fast`=1 and `gain` = 1 + the number of ones in the late taps `taps[2*SIDE+1:SIDE+2]`.
- R4: When `taps[SIDE]` and `taps[SIDE+1]` are both 0, the evaluation sets `fast`=0 and `gain` = 1 + the number of zeros in the early taps `taps[SIDE-1:0]`.
- R5: When `taps[SIDE]`=0 and `taps[SIDE+1]`=1 (the lock pattern), the evaluation sets `gain`=0 and `ctl_word` is left unchanged.
- R6: An evaluation subtracts `gain` from `ctl_word` when the oscillator is fast and adds `gain` when it is slow.
- R7: `ctl_word` saturates at 0 and at 255 instead of wrapping.
- R8: `lock` rises only on an evaluation whose snapshot shows the lock pattern when the previous evaluation also did. A single lock-pattern evaluation leaves `lock` at 0.
- R9: `lock` falls on the first evaluation that yields a nonzero `gain`.
- R10: Take an oscillator whose snapshot gives a gain equal to its word's distance from a target word, capped at SIDE+1. If the target lies within 40 codes of 128, `lock` is high within 18 reference cycles of reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| taps | input | 2*SIDE+2 | Delay-tap snapshot, 1 = tap already toggled |
| win_clr | output | 1 | Clear pulse for the sampling flip-flops; high in the non-evaluation cycle |
| ctl_word | output | 8 | Oscillator control word |
| fast | output | 1 | Last evaluation found the oscillator fast |
| gain | output | 4 | Step size chosen at the last evaluation |
| lock | output | 1 | Lock indication |

## Verification
On every cycle, the embedded assertions check three properties. Nothing moves outside evaluation edges. The word moves by at most the 4-bit step and pins at zero on an oversized subtract. Lock drops after a nonzero-gain evaluation. Only the directed scenarios can show that the decoded step sizes match the tap counts and that the lock flag waits for two consecutive lock snapshots. The scenarios also show that the high clamp holds and that a behavioural oscillator closes the loop within 18 reference cycles.

// File: rtl/adpll_pkg.sv
package adpll_pkg;
  localparam int GAIN_W = 4;
  localparam int WORD_W = 8;

  typedef struct packed {
    logic              fast;
    logic              lock_pat;
    logic [GAIN_W-1:0] gain;
  } decision_t;
endpackage

// File: rtl/adpll_tap_decode.sv
module adpll_tap_decode
  import adpll_pkg::*;
#(
  parameter int SIDE = 6
) (
  input  logic [2*SIDE+1:0] taps,
  output decision_t         dec
);
  localparam int CTR   = SIDE;
  localparam int LATE  = SIDE + 1;
  localparam int CNT_W = $clog2(SIDE + 2);
  localparam int GMAX  = (1 << GAIN_W) - 1;

  logic [CNT_W-1:0]  n_late_set;
  logic [CNT_W-1:0]  n_early_clr;
  logic [GAIN_W-1:0] gain_fast;
  logic [GAIN_W-1:0] gain_slow;

  // Count the taps set beyond the central pair and the early taps still clear.
  always_comb begin
    n_late_set  = '0;
    n_early_clr = '0;
    for (int i = 0; i < SIDE; i++) begin
      n_late_set  = n_late_set  + CNT_W'(taps[LATE+1+i]);
      n_early_clr = n_early_clr + CNT_W'(!taps[i]);
    end
  end

  // Separate step sizes for each direction, clamped to the gain width.
  always_comb begin
    gain_fast = (int'(n_late_set) + 1 > GMAX)  ? GAIN_W'(GMAX) : GAIN_W'(int'(n_late_set) + 1);
    gain_slow = (int'(n_early_clr) + 1 > GMAX) ? GAIN_W'(GMAX) : GAIN_W'(int'(n_early_clr) + 1);
  end

  // The fast flag selects the step; the lock pattern gives a zero step.
  always_comb begin
    dec.fast     = taps[CTR];
    dec.lock_pat = !taps[CTR] && taps[LATE];
    if (dec.fast)          dec.gain = gain_fast;
    else if (dec.lock_pat) dec.gain = '0;
    else                   dec.gain = gain_slow;
  end
endmodule

// File: rtl/adpll_ctrl_word.sv
module adpll_ctrl_word
  import adpll_pkg::*;
#(
  parameter int RESET_WORD = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              down,
  input  logic [GAIN_W-1:0] step,
  output logic [WORD_W-1:0] word
);
  localparam logic [WORD_W-1:0] WMAX = '1;

  logic [WORD_W-1:0] step_ext;
  logic [WORD_W:0]   sum;
  logic [WORD_W-1:0] word_nxt;

  always_comb begin
    step_ext = {{(WORD_W-GAIN_W){1'b0}}, step};
    sum      = {1'b0, word} + {1'b0, step_ext};
    word_nxt = word;
    if (en) begin
      if (down) word_nxt = (step_ext > word) ? '0 : word - step_ext;
      else      word_nxt = sum[WORD_W] ? WMAX : sum[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= WORD_W'(RESET_WORD);
    else        word <= word_nxt;
  end

  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(word));
  // R7
  floor_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && down && ({{(WORD_W-GAIN_W){1'b0}}, step} >= word)) |=> (word == '0));
  // R6
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (((word >= $past(word)) ? (word - $past(word)) : ($past(word) - word))
            <= WORD_W'((1 << GAIN_W) - 1)));
endmodule

// File: rtl/adpll_lock_det.sv
module adpll_lock_det (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pat,
  input  logic step_nz,
  output logic lock
);
  logic prev_pat;
  logic prev_pat_nxt;
  logic lock_nxt;

  always_comb begin
    prev_pat_nxt = prev_pat;
    lock_nxt     = lock;
    if (en) begin
      prev_pat_nxt = pat;
      if (step_nz)            lock_nxt = 1'b0;
      else if (pat && prev_pat) lock_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pat <= 1'b0;
      lock     <= 1'b0;
    end else begin
      prev_pat <= prev_pat_nxt;
      lock     <= lock_nxt;
    end
  end

  // R9
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step_nz) |=> !lock);
  // R2
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(lock));
endmodule

// File: rtl/adpll_gain_loop.sv
module adpll_gain_loop
  import adpll_pkg::*;
#(
  parameter int SIDE       = 6,
  parameter int RESET_WORD = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*SIDE+1:0] taps,
  output logic              win_clr,
  output logic [WORD_W-1:0] ctl_word,
  output logic              fast,
  output logic [GAIN_W-1:0] gain,
  output logic              lock
);
  logic              half;
  logic              eval_en;
  decision_t         dec;
  logic              fast_nxt;
  logic [GAIN_W-1:0] gain_nxt;

  // Reference divided by two: evaluate in every second cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half <= 1'b0;
    else        half <= !half;
  end

  assign eval_en = half;
  assign win_clr = !half;

  adpll_tap_decode #(.SIDE(SIDE)) u_decode (
    .taps (taps),
    .dec  (dec)
  );

  adpll_ctrl_word #(.RESET_WORD(RESET_WORD)) u_word (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (eval_en),
    .down  (dec.fast),
    .step  (dec.gain),
    .word  (ctl_word)
  );

  adpll_lock_det u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (eval_en),
    .pat     (dec.lock_pat),
    .step_nz (dec.gain != '0),
    .lock    (lock)
  );

  always_comb begin
    fast_nxt = fast;
    gain_nxt = gain;
    if (eval_en) begin
      fast_nxt = dec.fast;
      gain_nxt = dec.gain;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast <= 1'b0;
      gain <= '0;
    end else begin
      fast <= fast_nxt;
      gain <= gain_nxt;
    end
  end

  // R2
  clr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_clr |=> ($stable(ctl_word) && $stable(gain) && $stable(fast)));
  // R5
  zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && !taps[SIDE] && taps[SIDE+1]) |=> (gain == '0 && $stable(ctl_word)));
endmodule

// File: tb/adpll_gain_loop_tb.sv
module adpll_gain_loop_tb;
  localparam int SIDE = 6;
  localparam int TW   = 2*SIDE + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [TW-1:0] taps;
  logic          win_clr;
  logic [7:0]    ctl_word;
  logic          fast;
  logic [3:0]    gain;
  logic          lock;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  adpll_gain_loop #(.SIDE(SIDE)) u_dut (
    .clk(clk), .rst_n(rst_n), .taps(taps), .win_clr(win_clr),
    .ctl_word(ctl_word), .fast(fast), .gain(gain), .lock(lock)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] mk_fast(input int k);
    logic [TW-1:0] t = '0;
    for (int i = 0; i < SIDE; i++) t[i] = 1'b1;
    t[SIDE] = 1'b1;
    t[SIDE+1] = 1'b1;
    for (int i = 0; i < k; i++) t[SIDE+2+i] = 1'b1;
    return t;
  endfunction

  function automatic logic [TW-1:0] mk_slow(input int n);
    logic [TW-1:0] t = '0;
    for (int i = 0; i < SIDE - n; i++) t[i] = 1'b1;
    return t;
  endfunction

  function automatic logic [TW-1:0] mk_lock();
    logic [TW-1:0] t = '0;
    for (int i = 0; i < SIDE; i++) t[i] = 1'b1;
    t[SIDE+1] = 1'b1;
    return t;
  endfunction

  // Behavioural oscillator: step equals distance to target, capped at SIDE+1.
  function automatic logic [TW-1:0] osc_model(input int word, input int tgt);
    int e = word - tgt;
    if (e > 0)      return mk_fast((e - 1 > SIDE) ? SIDE : e - 1);
    else if (e < 0) return mk_slow((-e - 1 > SIDE) ? SIDE : -e - 1);
    else            return mk_lock();
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    taps  = mk_lock();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Present a snapshot for the next evaluation edge, then return after it.
  task automatic do_eval(input logic [TW-1:0] t);
    @(negedge clk);
    while (win_clr) @(negedge clk);
    taps = t;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    taps  = mk_fast(SIDE);
    repeat (2) @(negedge clk);
    check("R1 word in reset", ctl_word, 128);
    check("R1 lock in reset", lock, 0);
    check("R1 gain in reset", gain, 0);
    rst_n = 1'b1;
    check("R2 win_clr first cycle", win_clr, 1);
    @(negedge clk);
    check("R2 win_clr alternates", win_clr, 0);
    check("R2 no update on clear cycle", ctl_word, 128);
    @(negedge clk);
    check("R6 first evaluation subtracts", ctl_word, 121);
    check("R2 win_clr back high", win_clr, 1);
    @(negedge clk);
    check("R2 word held on clear edge", ctl_word, 121);
  endtask

  task automatic t_fast();
    do_reset();
    do_eval(mk_fast(3));
    check("R3 fast flag", fast, 1);
    check("R3 fast gain", gain, 4);
    check("R6 fast subtract", ctl_word, 124);
  endtask

  task automatic t_slow();
    do_reset();
    do_eval(mk_slow(2));
    check("R4 slow flag", fast, 0);
    check("R4 slow gain", gain, 3);
    check("R6 slow add", ctl_word, 131);
    do_eval(mk_slow(0));
    check("R4 slow minimum gain", gain, 1);
    check("R6 slow add min", ctl_word, 132);
  endtask

  task automatic t_lock();
    do_reset();
    do_eval(mk_slow(4));
    do_eval(mk_lock());
    check("R5 lock gain zero", gain, 0);
    check("R5 word unchanged", ctl_word, 133);
    check("R8 single pattern no lock", lock, 0);
    do_eval(mk_lock());
    check("R8 lock after two", lock, 1);
    do_eval(mk_fast(0));
    check("R9 lock dropped", lock, 0);
    check("R9 gain nonzero", gain, 1);
    check("R6 word after drop", ctl_word, 132);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 20; i++) do_eval(mk_fast(SIDE));
    check("R7 floor", ctl_word, 0);
    do_eval(mk_fast(SIDE));
    check("R7 floor holds", ctl_word, 0);
    do_reset();
    for (int i = 0; i < 20; i++) do_eval(mk_slow(SIDE));
    check("R7 ceiling", ctl_word, 255);
    do_eval(mk_slow(SIDE));
    check("R7 ceiling holds", ctl_word, 255);
  endtask

  task automatic t_acquire(input int tgt);
    int got = 0;
    do_reset();
    for (int c = 1; c <= 24; c++) begin
      taps = osc_model(int'(ctl_word), tgt);
      @(negedge clk);
      if (lock && got == 0) got = c;
    end
    check("R10 locked within 18 cycles", (got > 0 && got <= 18) ? 1 : 0, 1);
    check("R10 word at target", ctl_word, tgt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fast();
    t_slow();
    t_lock();
    t_saturate();
    t_acquire(168);
    t_acquire(93);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule